// File: doc/BRIEF.md
# Bit-Field Memory Operation Unit

This unit carries out one bit-field operation at a time on byte-addressed, big-endian memory. A field is given by a base byte address, a signed bit offset and a length of 1 to 32 bits. Bits are counted from the most significant bit of the base byte downward, so bit 0 is bit 7 of that byte. The unit first works out which bytes the field touches, which can be up to five. It reads those bytes one at a time in ascending address order into a window. It then extracts, rewrites or scans the field.

Operations that change memory write every spanned byte back in a second phase. Bits outside the field are written back with the values read. The unit returns a 32-bit result and condition flags that the caller uses for its status bits. Operations that only look at the field finish without a write phase.

Top module: `bitfield_mem_unit`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `mem_req`, `mem_we`, `result` and all four flags are 0.
- R2: A `field_len` of 0 selects a 32-bit field. Values 1 to 31 select that many bits.
- R3: The first field byte is `base_addr` plus the bit offset shifted arithmetically right by 3, which rounds down for negative offsets. The low three offset bits select the starting bit, where 0 means the byte's most significant bit.
- R4: The unit reads exactly (start bit + length − 1)/8 + 1 bytes, at most 5, at consecutive rising addresses from the first field byte. Each read is a one-cycle request. The data is taken from `mem_rdata` one cycle later.
- R5: Opcode 0 returns the field zero-extended, and so does opcode 7. Neither opcode writes memory.
- R6: Opcode 1 returns the field sign-extended from its most significant bit and does not write memory.
- R7: Opcode 2 writes the low `length` bits of `ins_value` into the field and leaves all other bits of the spanned bytes unchanged. It returns those bits left-aligned, with the field's first bit at result bit 31.
- R8: Opcodes 3, 4 and 5 invert, zero and fill the field respectively, leaving neighbouring bits unchanged. They return the old field left-aligned.
- R9: Opcode 6 returns the bit offset plus the number of leading zeros in the field. If the field is all zeros it returns the bit offset plus the length. It does not write memory.
- R10: `flag_n` is the first bit of the left-aligned value: the inserted value for opcode 2, the read field otherwise. `flag_z` is set when all bits of that value are 0. `flag_v` and `flag_c` are always 0.
- R11: `done` is a one-cycle pulse. `result` and the flags are valid with it and hold until the next completion. A `start` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation (taken only when idle) |
| opcode | input | 3 | Operation select |
| base_addr | input | ADDR_W | Base byte address |
| bit_offset | input | 32 | Signed bit offset from the base byte's MSB |
| field_len | input | 5 | Field length, 0 means 32 |
| ins_value | input | 32 | Value for insert, right-aligned |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Operation result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag, always 0 |
| flag_c | output | 1 | Carry flag, always 0 |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when set, read otherwise |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one cycle after a read request |

## Verification
The assertions assume a memory that returns read data exactly one cycle after a read request. They also assume that `bit_offset` plus the span never carries the address past the end of the address space. The bench memory model answers every read with that fixed latency. The stimulus keeps all fields inside a 256-byte array well away from its edges, including the negative-offset cases. Extra `start` pulses are driven only during the busy window, to show that they are ignored.

// File: rtl/bfu_pkg.sv
// Shared constants, operation codes and command record for the bit-field unit.
// Assumes fields of at most 32 bits, so a field spans at most 5 bytes.
package bfu_pkg;
    localparam int FLD_W  = 32;
    localparam int SPAN_B = (FLD_W + 7 + 7) / 8;
    localparam int WIN_W  = SPAN_B * 8;
    localparam int LEN_W  = $clog2(FLD_W) + 1;
    localparam int IDX_W  = $clog2(SPAN_B);

    typedef enum logic [2:0] {
        OP_EXTU = 3'd0,
        OP_EXTS = 3'd1,
        OP_INS  = 3'd2,
        OP_CHG  = 3'd3,
        OP_CLR  = 3'd4,
        OP_SET  = 3'd5,
        OP_FFO  = 3'd6,
        OP_RSV  = 3'd7
    } bfu_op_e;

    typedef struct packed {
        logic [2:0]       bit_in;
        logic [LEN_W-1:0] len;
        logic [IDX_W-1:0] last;
        bfu_op_e          op;
        logic [FLD_W-1:0] ins;
        logic [31:0]      ofs;
    } bfu_cmd_t;

    function automatic logic is_write_op(bfu_op_e op);
        return (op == OP_INS) || (op == OP_CHG) || (op == OP_CLR) || (op == OP_SET);
    endfunction
endpackage

// File: rtl/bfu_geom.sv
// Field geometry: turns base address, signed bit offset and length code into
// first byte address, starting bit, true length and last byte index.
// Assumes ADDR_W >= 3 and that the address arithmetic wraps silently.
module bfu_geom
    import bfu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [31:0]       bit_offset,
    input  logic [4:0]        len_code,
    output logic [ADDR_W-1:0] first_addr,
    output logic [2:0]        bit_in,
    output logic [LEN_W-1:0]  len,
    output logic [IDX_W-1:0]  last
);
    logic signed [31:0] byte_step;
    logic [LEN_W:0]     span_bits;

    // Normalise the offset to a floor byte step and a bit within the byte.
    always_comb begin
        byte_step  = $signed(bit_offset) >>> 3;
        first_addr = base_addr + ADDR_W'(byte_step);
        bit_in     = bit_offset[2:0];
        len        = (len_code == 5'd0) ? LEN_W'(FLD_W) : LEN_W'(len_code);
        span_bits  = (LEN_W+1)'(bit_in) + (LEN_W+1)'(len) - (LEN_W+1)'(1);
        last       = IDX_W'(span_bits >> 3);
    end
endmodule

// File: rtl/bfu_field.sv
// Field datapath: from the loaded byte window computes the field value,
// the rewritten window, the result word and the N/Z flags.
// Assumes len is 1..32 and window byte 0 sits in the top eight bits.
module bfu_field
    import bfu_pkg::*;
(
    input  logic [WIN_W-1:0] win,
    input  bfu_cmd_t         cmd,
    output logic [WIN_W-1:0] new_win,
    output logic [FLD_W-1:0] res,
    output logic             n_flag,
    output logic             z_flag
);
    logic [LEN_W-1:0] pad;
    logic [FLD_W-1:0] len_mask;
    logic [FLD_W-1:0] fld_left;
    logic [FLD_W-1:0] ins_left;
    logic [WIN_W-1:0] win_mask;
    logic [WIN_W-1:0] ins_win;
    logic [LEN_W-1:0] lead;

    // Align the field to the top of a word and build the window masks.
    always_comb begin
        pad      = LEN_W'(FLD_W) - cmd.len;
        len_mask = ~({FLD_W{1'b1}} >> cmd.len);
        fld_left = FLD_W'((win << cmd.bit_in) >> (WIN_W - FLD_W)) & len_mask;
        ins_left = cmd.ins << pad;
        win_mask = {len_mask, {(WIN_W-FLD_W){1'b0}}} >> cmd.bit_in;
        ins_win  = {ins_left, {(WIN_W-FLD_W){1'b0}}} >> cmd.bit_in;
    end

    // Count leading zeros of the aligned field.
    always_comb begin
        lead = LEN_W'(FLD_W);
        for (int i = 0; i < FLD_W; i++) begin
            if (fld_left[i]) lead = LEN_W'(FLD_W - 1 - i);
        end
    end

    // Rewrite the window for the modifying operations.
    always_comb begin
        case (cmd.op)
            OP_INS:  new_win = (win & ~win_mask) | ins_win;
            OP_CHG:  new_win = win ^ win_mask;
            OP_CLR:  new_win = win & ~win_mask;
            OP_SET:  new_win = win | win_mask;
            default: new_win = win;
        endcase
    end

    // Select the result word and flags.
    always_comb begin
        n_flag = fld_left[FLD_W-1];
        z_flag = (fld_left == '0);
        case (cmd.op)
            OP_EXTS: res = FLD_W'($signed(fld_left) >>> pad);
            OP_INS: begin
                res    = ins_left;
                n_flag = ins_left[FLD_W-1];
                z_flag = (ins_left == '0);
            end
            OP_CHG, OP_CLR, OP_SET: res = fld_left;
            OP_FFO: res = cmd.ofs + 32'((fld_left == '0) ? cmd.len : lead);
            default: res = fld_left >> pad;
        endcase
    end
endmodule

// File: rtl/bfu_seq.sv
// Access sequencer: reads the spanned bytes one per request into the window,
// then, for modifying operations, writes every spanned byte back.
// Assumes read data arrives exactly one cycle after a read request.
module bfu_seq
    import bfu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [IDX_W-1:0]  last_q,
    input  logic              wr_op,
    input  logic [WIN_W-1:0]  new_win,
    input  logic [7:0]        mem_rdata,
    output logic              accept,
    output logic              busy,
    output logic              fin,
    output logic [WIN_W-1:0]  win,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);
    typedef enum logic [2:0] {S_IDLE, S_RREQ, S_RWAIT, S_WR, S_FIN} seq_state_e;

    seq_state_e       state;
    logic [IDX_W-1:0] idx;

    assign accept = start && (state == S_IDLE);
    assign busy   = (state != S_IDLE);
    assign fin    = (state == S_FIN);

    // State, byte index and window capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            idx   <= '0;
            win   <= '0;
        end else begin
            case (state)
                S_IDLE: if (accept) begin
                    state <= S_RREQ;
                    idx   <= '0;
                    win   <= '0;
                end
                S_RREQ: state <= S_RWAIT;
                S_RWAIT: begin
                    for (int b = 0; b < SPAN_B; b++) begin
                        if (idx == IDX_W'(b)) win[(SPAN_B-1-b)*8 +: 8] <= mem_rdata;
                    end
                    if (idx == last_q) begin
                        idx   <= '0;
                        state <= wr_op ? S_WR : S_FIN;
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= S_RREQ;
                    end
                end
                S_WR: begin
                    if (idx == last_q) state <= S_FIN;
                    else idx <= idx + 1'b1;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Memory port drive.
    always_comb begin
        mem_req   = (state == S_RREQ) || (state == S_WR);
        mem_we    = (state == S_WR);
        mem_addr  = addr_q + ADDR_W'(idx);
        mem_wdata = '0;
        for (int b = 0; b < SPAN_B; b++) begin
            if (idx == IDX_W'(b)) mem_wdata = new_win[(SPAN_B-1-b)*8 +: 8];
        end
    end

    // R5
    ro_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> wr_op);
    // R4
    span_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> ((mem_addr - addr_q) <= ADDR_W'(last_q)));
    // R4
    read_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> !mem_req);
endmodule

// File: rtl/bitfield_mem_unit.sv
// Top of the bit-field unit: latches the command on start, runs the access
// sequencer and field datapath, and registers result and flags at completion.
// Assumes a byte memory with one-cycle read latency on the mem_* port.
module bitfield_mem_unit
    import bfu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        opcode,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [31:0]       bit_offset,
    input  logic [4:0]        field_len,
    input  logic [31:0]       ins_value,
    output logic              busy,
    output logic              done,
    output logic [31:0]       result,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_c,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);
    logic [ADDR_W-1:0] g_addr;
    logic [2:0]        g_bit;
    logic [LEN_W-1:0]  g_len;
    logic [IDX_W-1:0]  g_last;
    logic [ADDR_W-1:0] addr_q;
    bfu_cmd_t          cmd_q;
    logic              accept;
    logic              fin;
    logic [WIN_W-1:0]  win;
    logic [WIN_W-1:0]  new_win;
    logic [FLD_W-1:0]  res_c;
    logic              n_c;
    logic              z_c;

    bfu_geom #(.ADDR_W(ADDR_W)) u_geom (
        .base_addr  (base_addr),
        .bit_offset (bit_offset),
        .len_code   (field_len),
        .first_addr (g_addr),
        .bit_in     (g_bit),
        .len        (g_len),
        .last       (g_last)
    );

    // Latch the command when the sequencer accepts a start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cmd_q  <= '0;
        end else if (accept) begin
            addr_q       <= g_addr;
            cmd_q.bit_in <= g_bit;
            cmd_q.len    <= g_len;
            cmd_q.last   <= g_last;
            cmd_q.op     <= bfu_op_e'(opcode);
            cmd_q.ins    <= ins_value;
            cmd_q.ofs    <= bit_offset;
        end
    end

    bfu_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .addr_q    (addr_q),
        .last_q    (cmd_q.last),
        .wr_op     (is_write_op(cmd_q.op)),
        .new_win   (new_win),
        .mem_rdata (mem_rdata),
        .accept    (accept),
        .busy      (busy),
        .fin       (fin),
        .win       (win),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    bfu_field u_field (
        .win     (win),
        .cmd     (cmd_q),
        .new_win (new_win),
        .res     (res_c),
        .n_flag  (n_c),
        .z_flag  (z_c)
    );

    // Register the result and flags and raise the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            result <= '0;
            flag_n <= 1'b0;
            flag_z <= 1'b0;
        end else begin
            done <= fin;
            if (fin) begin
                result <= res_c;
                flag_n <= n_c;
                flag_z <= z_c;
            end
        end
    end

    assign flag_v = 1'b0;
    assign flag_c = 1'b0;

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(cmd_q) && $stable(addr_q)));
    // R9
    ffo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cmd_q.op == OP_FFO) |-> ((result - cmd_q.ofs) <= 32'(cmd_q.len)));
    // R4
    span_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (32'(g_last) < 32'(SPAN_B)));
endmodule

// File: tb/bitfield_mem_unit_test.sv
module bitfield_mem_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  opcode = '0;
    logic [31:0] base_addr = '0;
    logic [31:0] bit_offset = '0;
    logic [4:0]  field_len = '0;
    logic [31:0] ins_value = '0;
    logic        busy, done, flag_n, flag_z, flag_v, flag_c;
    logic [31:0] result;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    logic [7:0]  mem [256];
    logic [7:0]  exp_mem [256];
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    int          n_chk = 0;
    int          n_fail = 0;

    always #2 clk = ~clk;

    bitfield_mem_unit uut (.*);

    // Byte memory with one-cycle read latency.
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                mem[mem_addr[7:0]] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata <= mem[mem_addr[7:0]];
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_done(input string req);
        int cyc = 0;
        while (done !== 1'b1 && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        chk({req, " completion"}, {31'b0, done}, 32'd1);
    endtask

    // Reference computation on exp_mem, then run on the unit and compare.
    task automatic run_op(input logic [2:0] op, input int base, input int ofs,
                          input logic [4:0] len, input logic [31:0] ins, input string req);
        int L = (len == 0) ? 32 : int'(len);
        logic [31:0] fld = '0, left, ins_left, eres;
        logic en, ez;
        int first = -1, span, r0, w0, bad = 0;
        longint start_pos = longint'(base) * 8 + longint'(ofs);
        for (int i = 0; i < L; i++) begin
            longint p = start_pos + i;
            logic b = exp_mem[int'(p >>> 3) & 255][7 - int'(p & 7)];
            fld = {fld[30:0], b};
            if (b && first < 0) first = i;
        end
        left = fld << (32 - L);
        ins_left = ins << (32 - L);
        en = left[31];
        ez = (left == 0);
        case (op)
            3'd1: eres = 32'($signed(left) >>> (32 - L));
            3'd2: begin eres = ins_left; en = ins_left[31]; ez = (ins_left == 0); end
            3'd3, 3'd4, 3'd5: eres = left;
            3'd6: eres = 32'(ofs) + 32'((first < 0) ? L : first);
            default: eres = fld;
        endcase
        if (op inside {3'd2, 3'd3, 3'd4, 3'd5}) begin
            for (int i = 0; i < L; i++) begin
                longint p = start_pos + i;
                int bi = int'(p >>> 3) & 255;
                int bb = 7 - int'(p & 7);
                case (op)
                    3'd2: exp_mem[bi][bb] = ins[L - 1 - i];
                    3'd3: exp_mem[bi][bb] = ~exp_mem[bi][bb];
                    3'd4: exp_mem[bi][bb] = 1'b0;
                    default: exp_mem[bi][bb] = 1'b1;
                endcase
            end
        end
        span = (int'(start_pos & 7) + L - 1) / 8 + 1;
        r0 = rd_cnt;
        w0 = wr_cnt;
        @(negedge clk);
        opcode = op; base_addr = 32'(base); bit_offset = 32'(ofs);
        field_len = len; ins_value = ins; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(req);
        chk({req, " result"}, result, eres);
        chk({"R10 N for ", req}, {31'b0, flag_n}, {31'b0, en});
        chk({"R10 Z for ", req}, {31'b0, flag_z}, {31'b0, ez});
        chk("R10 V/C clear", {30'b0, flag_v, flag_c}, 32'd0);
        chk({"R4 read count ", req}, 32'(rd_cnt - r0), 32'(span));
        chk({req, " write count"}, 32'(wr_cnt - w0),
            (op inside {3'd2, 3'd3, 3'd4, 3'd5}) ? 32'(span) : 32'd0);
        for (int a = 0; a < 256; a++) if (mem[a] !== exp_mem[a]) bad++;
        chk({req, " memory image"}, 32'(bad), 32'd0);
        @(negedge clk);
        chk("R11 done lasts one cycle", {31'b0, done}, 32'd0);
    endtask

    task automatic poke(input int a, input logic [7:0] v);
        mem[a] = v;
        exp_mem[a] = v;
    endtask

    task automatic test_reset();
        chk("R1 busy after reset", {31'b0, busy}, 32'd0);
        chk("R1 done after reset", {31'b0, done}, 32'd0);
        chk("R1 mem_req after reset", {30'b0, mem_req, mem_we}, 32'd0);
        chk("R1 result after reset", result, 32'd0);
        chk("R1 flags after reset", {28'b0, flag_n, flag_z, flag_v, flag_c}, 32'd0);
    endtask

    task automatic test_extract();
        poke(8'h10, 8'hA5); poke(8'h11, 8'h3C);
        run_op(3'd0, 8'h10, 4, 5'd8, 0, "R5 unsigned extract");
        run_op(3'd7, 8'h10, 2, 5'd11, 0, "R5 opcode 7 extract");
        run_op(3'd1, 8'h10, 0, 5'd4, 0, "R6 signed extract negative");
        run_op(3'd1, 8'h10, 1, 5'd3, 0, "R6 signed extract positive");
    endtask

    task automatic test_length_and_offset();
        run_op(3'd0, 8'h20, 5, 5'd0, 0, "R2 length 0 as 32 over five bytes");
        run_op(3'd1, 8'h24, 0, 5'd0, 0, "R2 full 32-bit signed");
        run_op(3'd0, 8'h40, -3, 5'd6, 0, "R3 negative offset -3");
        run_op(3'd0, 8'h40, -13, 5'd12, 0, "R3 negative offset -13");
        run_op(3'd0, 8'h30, 37, 5'd1, 0, "R3 large offset single bit");
    endtask

    task automatic test_modify();
        run_op(3'd2, 8'h50, 3, 5'd10, 32'hFFFF_F2B5, "R7 insert keeps neighbours");
        run_op(3'd2, 8'h58, 6, 5'd0, 32'h8000_0001, "R7 insert 32 bits");
        run_op(3'd2, 8'h5E, 1, 5'd5, 32'h0, "R7 insert zero");
        run_op(3'd3, 8'h60, 7, 5'd9, 0, "R8 change");
        run_op(3'd4, 8'h68, -2, 5'd13, 0, "R8 clear");
        run_op(3'd5, 8'h70, 12, 5'd20, 0, "R8 set");
        run_op(3'd4, 8'h68, -2, 5'd13, 0, "R8 clear of cleared field");
    endtask

    task automatic test_ffo();
        for (int a = 8'h80; a < 8'h88; a++) poke(a, 8'h00);
        poke(8'h82, 8'h10);
        run_op(3'd6, 8'h80, 3, 5'd20, 0, "R9 first one found");
        run_op(3'd6, 8'h80, 2, 5'd12, 0, "R9 all zero field");
        run_op(3'd6, 8'h82, -4, 5'd8, 0, "R9 negative offset");
    endtask

    task automatic test_busy_start();
        int r0;
        @(negedge clk);
        opcode = 3'd0; base_addr = 32'h90; bit_offset = 32'd0;
        field_len = 5'd8; ins_value = 0; start = 1'b1;
        @(negedge clk);
        opcode = 3'd5; base_addr = 32'hA0; field_len = 5'd0;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        r0 = wr_cnt;
        wait_done("R11 start while busy");
        chk("R11 first command result kept", result, {24'b0, exp_mem[8'h90]});
        repeat (10) @(negedge clk);
        chk("R11 ignored start launches nothing", {31'b0, busy}, 32'd0);
        chk("R11 ignored start writes nothing", 32'(wr_cnt - r0), 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int a = 0; a < 256; a++) begin
            mem[a] = 8'(a * 29 + 7);
            exp_mem[a] = mem[a];
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_extract();
        test_length_and_offset();
        test_modify();
        test_ffo();
        test_busy_start();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule